// File: doc/BRIEF.md
# Pattern Table Bank Mapper

This block maps the picture processor's pattern-table space (addresses below 0x2000) onto a larger character ROM. Software loads eight 8-bit bank registers through a CPU write window, and the picture-side address is turned into a character-ROM address by combinational logic, in the same cycle the address is presented. Addresses at or above 0x2000 belong to nametable logic outside this block. For those addresses the block lowers its valid flag and drives a zero address.

Two page layouts exist. In the wide layout, four 2 KiB slots take their banks from registers 0, 1, 6 and 7. In the narrow layout, eight 1 KiB slots each take their bank from the register with the same index, and bits 5:4 of that register are copied into bank bits 9:8. A three-state machine holds the layout choice. `LAY_INIT` is entered at reset and uses the narrow layout. `LAY_WIDE` is reached from `LAY_INIT` by the transition `T_INIT_WIDE`, taken on a write to window offset 0x0000. `LAY_LOCK` uses the narrow layout and is reached by `T_INIT_LOCK` or `T_WIDE_LOCK`, taken on a write to any offset from 0x0312 to 0x0315. `LAY_LOCK` is never left except by reset. If both kinds of request arrive together, the lock wins.

Top module: `chr_bank_mapper`

## Requirements
- R1: A write with `wr_en` high at window offset 0x0310+i (i = 0..7) loads `wr_data` into bank register i at that clock edge.
- R2: A cycle with `wr_en` low, or a write to any offset other than 0x0000 and 0x0310..0x0317, changes no bank register and no layout state.
- R3: From `LAY_INIT`, a write to offset 0x0000 (data ignored) selects the wide layout. That layout stays selected through later writes to 0x0310, 0x0311, 0x0316 and 0x0317.
- R4: A write to any offset from 0x0312 to 0x0315 selects the narrow layout permanently. After that, a write to 0x0000 does not bring the wide layout back.
- R5: In the wide layout, the slot is `ppu_addr[12:11]`. Slots 0, 1, 2 and 3 use registers 0, 1, 6 and 7, and `chr_addr` = bank*0x800 + `ppu_addr[10:0]`.
- R6: In the narrow layout, the slot is `ppu_addr[12:10]` and register i serves slot i. The effective bank is reg | ((reg & 0x30) << 4), and `chr_addr` = effective bank*0x400 + `ppu_addr[9:0]`.
- R7: For `ppu_addr` below 0x2000, `chr_valid` is 1. For `ppu_addr` at or above 0x2000, `chr_valid` is 0 and `chr_addr` is 0. The output follows `ppu_addr` with no clock edge in between.
- R8: Reset clears all bank registers and returns the machine to `LAY_INIT`, so the narrow layout applies after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU window write strobe |
| wr_addr | input | 16 | Window offset of the write |
| wr_data | input | 8 | Write data |
| ppu_addr | input | 14 | Picture-side address |
| chr_addr | output | 20 | Character-ROM byte address |
| chr_valid | output | 1 | High when `ppu_addr` lies in pattern-table space |

## Verification
The address is probed in every state. In `LAY_INIT`, probe 0x0400 separates the narrow layout from the wide one: it gives 0 in the narrow layout and 0x400 in the wide layout. In `LAY_WIDE`, probes 0x1234 and 0x1FFF reach registers 6 and 7, which shows that the wide layout remaps its upper slots. The register values have bits 5:4 set in some cases and clear in others, so the copy into bank bits 9:8 is shown to appear only in the narrow layout. Writes that are disabled or fall outside the decoded offsets, a repeated 0x0000 write after the lock, and out-of-range addresses show that nothing leaks into the state or onto the outputs.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
    localparam int PPU_AW   = 14;
    localparam int WIN_AW   = 16;
    localparam logic [WIN_AW-1:0] OFS_WIDE_REQ = 16'h0000;
    localparam logic [WIN_AW-1:0] OFS_BANK0    = 16'h0310;
    localparam int NARROW_LO = 2;
    localparam int NARROW_HI = 5;

    typedef enum logic [1:0] {
        LAY_INIT = 2'd0,
        LAY_WIDE = 2'd1,
        LAY_LOCK = 2'd2
    } layout_e;
endpackage

// File: rtl/chr_wr_decode.sv
module chr_wr_decode
    import chr_map_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                  wr_en,
    input  logic [WIN_AW-1:0]     wr_addr,
    output logic [NUM_BANKS-1:0]  bank_we,
    output logic                  wide_req,
    output logic                  narrow_hit
);
    localparam int IDX_W = $clog2(NUM_BANKS);

    logic             in_bank_page;
    logic [IDX_W-1:0] idx;

    assign in_bank_page = wr_en && (wr_addr[WIN_AW-1:IDX_W] == OFS_BANK0[WIN_AW-1:IDX_W]);
    assign idx          = wr_addr[IDX_W-1:0];
    assign wide_req     = wr_en && (wr_addr == OFS_WIDE_REQ);
    assign narrow_hit   = in_bank_page && (int'(idx) >= NARROW_LO) && (int'(idx) <= NARROW_HI);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_we
        assign bank_we[g] = in_bank_page && (int'(idx) == g);
    end
endmodule

// File: rtl/chr_layout_fsm.sv
module chr_layout_fsm
    import chr_map_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wide_req,
    input  logic    narrow_hit,
    output layout_e state_q,
    output logic    wide_mode
);
    layout_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LAY_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAY_INIT: begin
                if (narrow_hit)    state_d = LAY_LOCK;
                else if (wide_req) state_d = LAY_WIDE;
            end
            LAY_WIDE: begin
                if (narrow_hit)    state_d = LAY_LOCK;
            end
            LAY_LOCK: state_d = LAY_LOCK;
            default:  state_d = LAY_INIT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LAY_WIDE: wide_mode = 1'b1;
            default:  wide_mode = 1'b0;
        endcase
    end
endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_BANKS-1:0]               bank_we,
    input  logic [BANK_W-1:0]                  wr_data,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]   bank_q
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bank_q[g] <= '0;
            else if (bank_we[g]) bank_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/chr_addr_xlate.sv
module chr_addr_xlate
    import chr_map_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8,
    parameter int CHR_AW    = 20
) (
    input  logic                              wide_mode,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]  bank_q,
    input  logic [PPU_AW-1:0]                 ppu_addr,
    output logic [CHR_AW-1:0]                 chr_addr,
    output logic                              chr_valid
);
    localparam int PAGE1K_W = 10;
    localparam int PAGE2K_W = PAGE1K_W + 1;
    localparam int REP_LO   = 4;
    localparam int FULL_W   = 2 + BANK_W + PAGE1K_W;

    logic [2:0]        slot1k;
    logic [1:0]        slot2k;
    logic [2:0]        sel2k;
    logic [BANK_W-1:0] bank1k;
    logic [BANK_W-1:0] bank2k;
    logic [FULL_W-1:0] addr1k;
    logic [FULL_W-1:0] addr2k;

    assign slot1k = ppu_addr[12:10];
    assign slot2k = ppu_addr[12:11];
    // upper wide slots are served by the last two registers
    assign sel2k  = {slot2k[1], slot2k[1], slot2k[0]};
    assign bank1k = bank_q[slot1k];
    assign bank2k = bank_q[sel2k];

    assign addr1k = {bank1k[REP_LO+1:REP_LO], bank1k, ppu_addr[PAGE1K_W-1:0]};
    assign addr2k = {1'b0, bank2k, ppu_addr[PAGE2K_W-1:0]};

    always_comb begin
        chr_valid = !ppu_addr[PPU_AW-1];
        chr_addr  = '0;
        if (chr_valid)
            chr_addr = wide_mode ? CHR_AW'(addr2k) : CHR_AW'(addr1k);
    end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
    import chr_map_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8,
    parameter int CHR_AW    = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [15:0]          wr_addr,
    input  logic [BANK_W-1:0]    wr_data,
    input  logic [13:0]          ppu_addr,
    output logic [CHR_AW-1:0]    chr_addr,
    output logic                 chr_valid
);
    logic [NUM_BANKS-1:0]             bank_we;
    logic                             wide_req;
    logic                             narrow_hit;
    logic                             wide_mode;
    layout_e                          layout_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q;

    chr_wr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .bank_we(bank_we),
        .wide_req(wide_req), .narrow_hit(narrow_hit)
    );

    chr_layout_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wide_req(wide_req), .narrow_hit(narrow_hit),
        .state_q(layout_q), .wide_mode(wide_mode)
    );

    chr_bank_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .wr_data(wr_data), .bank_q(bank_q)
    );

    chr_addr_xlate #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CHR_AW(CHR_AW)) u_xl (
        .wide_mode(wide_mode), .bank_q(bank_q), .ppu_addr(ppu_addr),
        .chr_addr(chr_addr), .chr_valid(chr_valid)
    );
endmodule

// File: rtl/chr_bank_mapper_chk.sv
module chr_bank_mapper_chk
    import chr_map_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 8,
    parameter int CHR_AW    = 20
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [15:0]                      wr_addr,
    input logic [BANK_W-1:0]                wr_data,
    input logic [13:0]                      ppu_addr,
    input logic [CHR_AW-1:0]                chr_addr,
    input logic                             chr_valid,
    input layout_e                          layout,
    input logic [NUM_BANKS-1:0][BANK_W-1:0] banks
);
    p_load_bank0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 16'h0310) |=> banks[0] == $past(wr_data));

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(banks) && $stable(layout)));

    p_enter_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == LAY_INIT && wr_en && wr_addr == 16'h0000) |=> layout == LAY_WIDE);

    p_no_return_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        layout != LAY_INIT |=> layout != LAY_INIT);

    p_enter_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= 16'h0312 && wr_addr <= 16'h0315) |=> layout == LAY_LOCK);

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        layout == LAY_LOCK |=> layout == LAY_LOCK);

    p_wide_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == LAY_WIDE && chr_valid) |-> chr_addr[10:0] == ppu_addr[10:0]);

    p_narrow_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (layout != LAY_WIDE && chr_valid) |-> chr_addr[9:0] == ppu_addr[9:0]);

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_valid |-> chr_addr == '0);
endmodule

bind chr_bank_mapper chr_bank_mapper_chk #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CHR_AW(CHR_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ppu_addr(ppu_addr), .chr_addr(chr_addr), .chr_valid(chr_valid),
    .layout(layout_q), .banks(bank_q)
);

// File: tb/chr_bank_mapper_test.sv
module chr_bank_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [13:0] ppu_addr = '0;
    logic [19:0] chr_addr;
    logic        chr_valid;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    chr_bank_mapper uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ppu_addr(ppu_addr), .chr_addr(chr_addr), .chr_valid(chr_valid)
    );

    task automatic probe(input string req, input logic [13:0] pa,
                         input logic [19:0] exp_a, input logic exp_v);
        ppu_addr = pa;
        #1;
        vectors++;
        if (chr_addr !== exp_a || chr_valid !== exp_v) begin
            miscompares++;
            $display("FAIL %s ppu=%h: got addr=%h valid=%b, expected addr=%h valid=%b",
                     req, pa, chr_addr, chr_valid, exp_a, exp_v);
        end
    endtask

    task automatic win_write(input logic en, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        probe("R8", 14'h0000, 20'h00000, 1'b1);
        probe("R8", 14'h0400, 20'h00000, 1'b1);
        probe("R8", 14'h1ABC, 20'h002BC, 1'b1);
    endtask

    task automatic t_ignored_init();
        win_write(1'b0, 16'h0000, 8'h00);
        probe("R2", 14'h0400, 20'h00000, 1'b1);
        win_write(1'b1, 16'h0318, 8'hAA);
        win_write(1'b0, 16'h0310, 8'h99);
        probe("R2", 14'h0000, 20'h00000, 1'b1);
    endtask

    task automatic t_narrow_init();
        win_write(1'b1, 16'h0310, 8'h05);
        win_write(1'b1, 16'h0311, 8'h31);
        win_write(1'b1, 16'h0316, 8'h7A);
        win_write(1'b1, 16'h0317, 8'hFF);
        probe("R1_R6", 14'h0010, 20'h01410, 1'b1);
        probe("R6", 14'h0523, 20'hCC523, 1'b1);
        probe("R6", 14'h1BCD, 20'hDEBCD, 1'b1);
    endtask

    task automatic t_wide();
        win_write(1'b1, 16'h0000, 8'h5A);
        probe("R3_R5", 14'h0123, 20'h02923, 1'b1);
        probe("R5", 14'h0923, 20'h18923, 1'b1);
        probe("R5", 14'h1234, 20'h3D234, 1'b1);
        probe("R5", 14'h1FFF, 20'h7FFFF, 1'b1);
        win_write(1'b0, 16'h0310, 8'h99);
        win_write(1'b1, 16'h030F, 8'h11);
        win_write(1'b1, 16'h0318, 8'h22);
        win_write(1'b0, 16'h0313, 8'h33);
        probe("R2", 14'h0123, 20'h02923, 1'b1);
        win_write(1'b1, 16'h0317, 8'h80);
        probe("R3", 14'h1FFF, 20'h407FF, 1'b1);
    endtask

    task automatic t_lock();
        win_write(1'b1, 16'h0314, 8'h12);
        probe("R4_R6", 14'h1001, 20'h44801, 1'b1);
        probe("R4", 14'h1FFF, 20'h203FF, 1'b1);
        win_write(1'b1, 16'h0000, 8'h00);
        probe("R4", 14'h1FFF, 20'h203FF, 1'b1);
        probe("R4", 14'h0400, 20'hCC400, 1'b1);
    endtask

    task automatic t_range();
        probe("R7", 14'h2000, 20'h00000, 1'b0);
        probe("R7", 14'h2ABC, 20'h00000, 1'b0);
        probe("R7", 14'h3FFF, 20'h00000, 1'b0);
        probe("R7", 14'h1FFF, 20'h203FF, 1'b1);
    endtask

    task automatic t_rereset();
        do_reset();
        probe("R8", 14'h0400, 20'h00000, 1'b1);
        probe("R8", 14'h1FFF, 20'h003FF, 1'b1);
        win_write(1'b1, 16'h0000, 8'h00);
        probe("R3_R8", 14'h0400, 20'h00400, 1'b1);
    endtask

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        t_ignored_init();
        t_narrow_init();
        t_wide();
        t_lock();
        t_range();
        t_rereset();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule